// File: doc/BRIEF.md
# Double-Buffered Clock Register Front End

This block sits between a byte-wide bus and the timekeeping core of a battery-backed RAM. It decodes a 15-bit address space. The eight highest locations are clock registers, and every lower location is an ordinary byte of RAM. A calendar unit outside the block keeps the running time and reports it on `live_time`. The block keeps a second, user-visible copy of each time byte. The bus reads and writes only that copy.

Without a hold, the copies follow the running count. A control byte holds a write-hold bit, a read-hold bit and a six-bit BCD century. Setting either hold bit freezes the copies, so software can read or rewrite a consistent set of fields while the calendar keeps counting. Releasing the write hold sends every copy back to the calendar as a single masked load command. Releasing the read hold only resumes the refresh, and all fields refresh on the same edge. A time byte written with no hold set is not lost. The copy keeps the written value, and the field goes to the calendar with the next tick.

The bus is a synchronous model of chip-enable, write-enable and output-enable, each active low and sampled on the rising clock. Read data comes back one cycle later with `rd_valid`, which acts as the valid strobe of a stream that has no ready. The bus cannot stall, so there is no back-pressure: the requester must take each returned byte in the cycle it is flagged. `load_valid` is a one-cycle command to the calendar with no ready either. The calendar must apply it on the next edge, and a load takes precedence over a tick.

Top module: `tkr_regs`

## Requirements
- R1: A write to an address below 7FF8h stores the byte in RAM, and a later read of the same address returns it. RAM is indexed by the low RAM_AW address bits.
- R2: Addresses 7FF8h to 7FFFh, in ascending order, select control, seconds, minutes, hours, day, date, month and year. Field index 0 to 7 is the address minus 7FF8h. A control read returns {write hold in bit 7, read hold in bit 6, century in bits 5:0}. With no hold set, a time read returns the running count.
- R3: While either hold bit is 1, the user copies keep the values they had on the edge where the hold began, even as `live_time` advances. Bus writes to the copies are the only exception.
- R4: A control write with bits 7:6 = 00 while the write hold is set clears both holds and stores data bits 5:0 as the century. In the next cycle it asserts `load_valid` for one cycle, with `load_mask` = FFh and `load_time` = all copies, where byte 0 = {00, new century}.
- R5: A control write with bit 7 or bit 6 set loads bit 7 into the write hold and bit 6 into the read hold. The century keeps its old value whatever bits 5:0 carry.
- R6: A control write with bits 7:6 = 00 while only the read hold is set clears it, leaves the century unchanged and issues no load.
- R7: Once holds are clear and no load is in flight, every copy takes `live_time` on the same edge. A read issued two cycles after the releasing write already returns the refreshed values.
- R8: The bus registers a read when ce_n=0, oe_n=0 and we_n=1, and a write when ce_n=0 and we_n=0; any other combination does nothing. `rdata` carries the read byte, with `rd_valid` = 1, in the cycle after the read. Otherwise `rd_valid` = 0 and `rdata` = 0.
- R9: While the write hold is set, bus writes to time registers change only the copies, and `load_valid` stays low until the releasing control write.
- R10: A time or control write with no hold set places the byte in the copy at once and marks the field pending. The cycle after the next `tick` brings `load_valid` with `load_mask` bit i set for each pending field i and that byte in `load_time`.
- R11: After reset, `rd_valid` and `load_valid` are 0 and both hold bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when not valid |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| tick | input | 1 | One-cycle pulse when the calendar advances |
| live_time | input | 64 | Running count, byte i = field i |
| load_valid | output | 1 | One-cycle load command to the calendar |
| load_mask | output | 8 | Fields to load, bit i = field i |
| load_time | output | 64 | Values to load, byte i = field i |

## Verification
The bench goes after the century rules of the control byte. A design that copied bits 5:0 on every control write would show a wrong century after a hold is set or after a read-hold release. One that ignored them on a write-hold release would load the old century into the calendar. The bench reads a field immediately after release, two cycles after the write. A design with a late or one-field-at-a-time refresh would return stale time there, and one that refreshed on the load cycle would briefly show the pre-load count. A field written while running must reach the calendar only after a tick. A design that dropped the write would read back the running count, and one that loaded at once or while held would produce a load command the bench does not expect.

// File: rtl/tkr_pkg.sv
package tkr_pkg;
  localparam int BYTE_W    = 8;
  localparam int NFIELD    = 8;
  localparam int FIELD_W   = $clog2(NFIELD);
  localparam int CEN_W     = 6;
  localparam int WHOLD_BIT = 7;
  localparam int RHOLD_BIT = 6;
  localparam int TIME_W    = NFIELD * BYTE_W;

  // Decoded bus access for one cycle.
  typedef struct packed {
    logic               rd;
    logic               wr;
    logic               clk_sel;
    logic [FIELD_W-1:0] field;
  } bus_cmd_t;
endpackage

// File: rtl/tkr_decode.sv
module tkr_decode
  import tkr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int RAM_AW = 10
) (
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output bus_cmd_t          cmd,
  output logic [RAM_AW-1:0] ram_addr
);
  // Clock window: every address bit above the field index is 1.
  assign cmd.wr      = !ce_n && !we_n;
  assign cmd.rd      = !ce_n && !oe_n && we_n;
  assign cmd.clk_sel = &addr[ADDR_W-1:FIELD_W];
  assign cmd.field   = addr[FIELD_W-1:0];
  assign ram_addr    = addr[RAM_AW-1:0];
endmodule

// File: rtl/tkr_ram.sv
module tkr_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/tkr_shadow.sv
module tkr_shadow
  import tkr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] field,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic               tick,
  input  logic [TIME_W-1:0]  live_time,
  output logic [TIME_W-1:0]  view_flat,
  output logic               load_valid,
  output logic [NFIELD-1:0]  load_mask,
  output logic [TIME_W-1:0]  load_time
);
  logic                whold_q, rhold_q, hold_q;
  logic [CEN_W-1:0]    cen_q;
  logic [NFIELD-1:0]   pend_q, pend_d, wr_vec;
  logic [TIME_W-1:0]   tim_flat;
  logic                ctrl_wr, any_hold_bit, rel_w, rel_r, plain_c;
  logic                refresh_ok, flush;
  wire                 unused_live = ^live_time[BYTE_W-1:CEN_W];

  assign hold_q       = whold_q || rhold_q;
  assign ctrl_wr      = wr_en && (field == '0);
  assign any_hold_bit = wdata[WHOLD_BIT] || wdata[RHOLD_BIT];
  assign rel_w        = ctrl_wr && !any_hold_bit && whold_q;
  assign rel_r        = ctrl_wr && !any_hold_bit && !whold_q && rhold_q;
  assign plain_c      = ctrl_wr && !any_hold_bit && !hold_q;
  assign refresh_ok   = !hold_q && !load_valid;
  assign flush        = tick && (|pend_q) && !whold_q && !rel_w;

  // Hold bits follow every control write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      whold_q <= 1'b0;
      rhold_q <= 1'b0;
    end else if (ctrl_wr) begin
      whold_q <= wdata[WHOLD_BIT];
      rhold_q <= wdata[RHOLD_BIT];
    end
  end

  // Century copy: written on write-hold release or plain write, else refreshed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cen_q <= '0;
    else if (rel_w || plain_c)       cen_q <= wdata[CEN_W-1:0];
    else if (refresh_ok && !pend_q[0]) cen_q <= live_time[CEN_W-1:0];
  end

  assign tim_flat[BYTE_W-1:0] = {2'b00, cen_q};
  assign wr_vec[0]            = plain_c;

  genvar gi;
  generate
    for (gi = 1; gi < NFIELD; gi++) begin : g_fld
      logic [BYTE_W-1:0] byte_q;
      logic              hit;
      assign hit = wr_en && (field == FIELD_W'(gi));
      assign wr_vec[gi] = hit && !hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        byte_q <= '0;
        else if (hit)                      byte_q <= wdata;
        else if (refresh_ok && !pend_q[gi]) byte_q <= live_time[gi*BYTE_W +: BYTE_W];
      end
      assign tim_flat[gi*BYTE_W +: BYTE_W] = byte_q;
    end
  endgenerate

  assign view_flat = {tim_flat[TIME_W-1:BYTE_W], whold_q, rhold_q, cen_q};

  always_comb begin
    pend_d = (flush || rel_w) ? '0 : pend_q;
    if (!rel_w) pend_d = pend_d | wr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      load_valid <= 1'b0;
      load_mask  <= '0;
      load_time  <= '0;
    end else begin
      pend_q     <= pend_d;
      load_valid <= rel_w || flush;
      if (rel_w) begin
        load_mask <= '1;
        load_time <= {tim_flat[TIME_W-1:BYTE_W], 2'b00, wdata[CEN_W-1:0]};
      end else if (flush) begin
        load_mask <= pend_q;
        load_time <= tim_flat;
      end
    end
  end

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !wr_en) |=> ($stable(tim_flat)));

  assert_wload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_w |=> (load_valid && load_mask == '1 &&
               load_time[CEN_W-1:0] == $past(wdata[CEN_W-1:0]) &&
               !whold_q && !rhold_q));

  assert_keep_century_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && any_hold_bit && hold_q) |=> $stable(cen_q));

  assert_rrel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rel_r |=> (!load_valid && $stable(cen_q)));

  assert_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && !load_valid && pend_q == '0 && !wr_en) |=>
      (tim_flat[TIME_W-1:BYTE_W] == $past(live_time[TIME_W-1:BYTE_W]) &&
       cen_q == $past(live_time[CEN_W-1:0])));

  assert_noload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (whold_q && !rel_w) |=> !load_valid);
endmodule

// File: rtl/tkr_regs.sv
module tkr_regs
  import tkr_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int RAM_AW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_n,
  input  logic                 we_n,
  input  logic                 oe_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BYTE_W-1:0]    wdata,
  output logic [BYTE_W-1:0]    rdata,
  output logic                 rd_valid,
  input  logic                 tick,
  input  logic [TIME_W-1:0]    live_time,
  output logic                 load_valid,
  output logic [NFIELD-1:0]    load_mask,
  output logic [TIME_W-1:0]    load_time
);
  bus_cmd_t          cmd;
  logic [RAM_AW-1:0] ram_addr;
  logic [BYTE_W-1:0] ram_q, clk_q;
  logic [TIME_W-1:0] view_flat;
  logic              sel_clk_q;

  tkr_decode #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_dec (
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .cmd(cmd), .ram_addr(ram_addr)
  );

  tkr_ram #(.AW(RAM_AW), .DW(BYTE_W)) u_ram (
    .clk(clk), .we(cmd.wr && !cmd.clk_sel), .addr(ram_addr),
    .wdata(wdata), .rdata(ram_q)
  );

  tkr_shadow u_shd (
    .clk(clk), .rst_n(rst_n), .wr_en(cmd.wr && cmd.clk_sel),
    .field(cmd.field), .wdata(wdata), .tick(tick), .live_time(live_time),
    .view_flat(view_flat), .load_valid(load_valid),
    .load_mask(load_mask), .load_time(load_time)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      sel_clk_q <= 1'b0;
      clk_q     <= '0;
    end else begin
      rd_valid <= cmd.rd;
      if (cmd.rd) begin
        sel_clk_q <= cmd.clk_sel;
        clk_q     <= view_flat[cmd.field*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rdata = rd_valid ? (sel_clk_q ? clk_q : ram_q) : '0;

  assert_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!ce_n && !oe_n && we_n));
endmodule

// File: tb/tkr_regs_test.sv
`timescale 1ns/1ps
module tkr_regs_test;
  localparam int AW  = 15;
  localparam int RAW = 10;

  logic        clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, tick = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rd_valid, load_valid;
  logic [7:0]  load_mask;
  logic [63:0] load_time, live_time;
  logic [7:0]  cal [8];

  int n_cmp = 0, n_err = 0, load_cnt = 0;
  logic [7:0]  last_mask = '0;
  logic [63:0] last_time = '0;
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  tkr_regs #(.ADDR_W(AW), .RAM_AW(RAW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
    .tick(tick), .live_time(live_time), .load_valid(load_valid),
    .load_mask(load_mask), .load_time(load_time)
  );

  always_comb for (int i = 0; i < 8; i++) live_time[i*8 +: 8] = cal[i];

  // Calendar stand-in: tick bumps seconds, a load overrides masked fields.
  always @(posedge clk) begin
    if (!rst_n) begin
      cal[0] <= 8'h20; cal[1] <= 8'h10; cal[2] <= 8'h05; cal[3] <= 8'h08;
      cal[4] <= 8'h03; cal[5] <= 8'h15; cal[6] <= 8'h06; cal[7] <= 8'h24;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (load_valid && load_mask[i]) cal[i] <= load_time[i*8 +: 8];
        else if (tick && i == 1)        cal[i] <= cal[i] + 8'd1;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data whenever the design flags a result.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R8 unexpected read data", {56'd0, rdata}, 64'hDEAD);
      else chk(tag_q.pop_front(), {56'd0, rdata}, {56'd0, exp_q.pop_front()});
    end
    if (rst_n && load_valid) begin
      load_cnt++;
      last_mask = load_mask;
      last_time = load_time;
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    idle(4);
    chk("R11 rd_valid in reset", {63'd0, rd_valid}, 64'd0);
    chk("R11 load_valid in reset", {63'd0, load_valid}, 64'd0);
    rst_n = 1'b1;
    idle(3);
    rd(15'h7FF8, 8'h20, "R11 holds clear, R2 control byte");

    // R1: RAM bytes, including the last RAM address.
    wr(15'h0005, 8'hA5);
    wr(15'h7FF7, 8'h3C);
    rd(15'h0005, 8'hA5, "R1 ram low");
    rd(15'h7FF7, 8'h3C, "R1 ram top");

    // R2: running count visible with no hold.
    rd(15'h7FF9, 8'h10, "R2 seconds");
    rd(15'h7FFB, 8'h08, "R2 hours");
    rd(15'h7FFF, 8'h24, "R2 year");

    // R5 + R3: read hold, century bits in the write ignored.
    wr(15'h7FF8, 8'h51);
    rd(15'h7FF8, 8'h60, "R5 century kept on hold set");
    pulse_tick(); pulse_tick(); pulse_tick();
    rd(15'h7FF9, 8'h10, "R3 seconds frozen under read hold");

    // R6 + R7: release read hold, read two cycles later.
    wr(15'h7FF8, 8'h3F);
    rd(15'h7FF8, 8'h20, "R6 century kept on read release");
    rd(15'h7FF9, 8'h13, "R7 seconds refreshed after release");
    rd(15'h7FFF, 8'h24, "R7 year refreshed");
    chk("R6 no load on read release", load_cnt, 0);

    // R9 + R4: write hold, edit copies, release with new century.
    wr(15'h7FF8, 8'h85);
    rd(15'h7FF8, 8'hA0, "R5 century kept on write hold set");
    wr(15'h7FF9, 8'h45);
    wr(15'h7FFA, 8'h30);
    wr(15'h7FFF, 8'h99);
    pulse_tick(); pulse_tick();
    rd(15'h7FF9, 8'h45, "R9 copy holds written seconds");
    chk("R9 no load while write hold", load_cnt, 0);
    chk("R3 counter kept running", {56'd0, cal[1]}, 64'h15);
    wr(15'h7FF8, 8'h19);
    rd(15'h7FF8, 8'h19, "R4 century from release write");
    rd(15'h7FF9, 8'h45, "R4 seconds after load");
    chk("R4 one load", load_cnt, 1);
    chk("R4 load mask", {56'd0, last_mask}, 64'hFF);
    chk("R4 load image", last_time, 64'h99061503_08304519);

    // R10: write while running, applied after the next tick.
    wr(15'h7FFA, 8'h12);
    rd(15'h7FFA, 8'h12, "R10 copy shows written minutes");
    chk("R10 no load before tick", load_cnt, 1);
    pulse_tick();
    idle(2);
    chk("R10 load after tick", load_cnt, 2);
    chk("R10 mask minutes", {56'd0, last_mask}, 64'h04);
    chk("R10 minutes value", {56'd0, last_time[23:16]}, 64'h12);
    rd(15'h7FFA, 8'h12, "R10 minutes after load");
    rd(15'h7FF9, 8'h46, "R10 seconds kept counting");

    // R8: write without chip enable, read without output enable.
    @(negedge clk); addr = 15'h0005; wdata = 8'h00; ce_n = 1'b1; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    rd(15'h0005, 8'hA5, "R8 write ignored without chip enable");
    @(negedge clk); addr = 15'h0005; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
    chk("R8 no read data without output enable", {63'd0, rd_valid}, 64'd0);
    chk("R8 rdata zero when idle", {56'd0, rdata}, 64'd0);

    idle(4);
    chk("R8 all reads answered", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule